// File: doc/BRIEF.md
# Screen Band Tile Mask Generator

This block tags each draw command with the set of large screen regions its output can reach. During a depth-only pre-pass the bounding box of every command, in pixels, is already known. The block takes that box together with the command identifier and returns a small bitmask with one bit per screen region. That mask becomes the command's header in a header store. When a later colour pass renders one region at a time, the command fetcher reads the header and skips any command whose bit for that region is clear. A command whose box crosses a region boundary gets a bit for every region it touches, so the fetcher replays it once per region.

The regions are horizontal bands. Configuration inputs set the last row of each band and the number of bands in use, from one up to a parameter maximum. Band 0 starts at row 0, and each later band starts on the row after the previous band's last row. Each command moves through two register stages with a valid/ready handshake at both ends. With no stall it sustains one command per cycle.

Top module: `tile_mask_gen`

## Requirements
- R1: While reset is held and in the cycle after it is released, `hdr_valid` is 0 and `in_ready` is 1.
- R2: A command accepted at a clock edge, with `hdr_ready` high at the following edge, appears on `hdr_valid` after that second edge.
- R3: Mask bit i is 1 exactly when band i is in use, the box is well formed and on screen, and the inclusive row ranges [min_y, max_y] and [top_i, last_i] overlap. Here top_0 = 0 and top_i = last_(i-1) + 1.
- R4: A box that spans one or more band boundaries sets the bit of every band it overlaps.
- R5: A box with min_y greater than max_y, or min_x greater than max_x, gives an all-zero mask.
- R6: A box with min_x at or beyond `cfg_screen_w`, or with min_y below the last row of the last band in use, gives an all-zero mask.
- R7: Mask bits at positions greater than `cfg_band_cnt_m1` are always 0.
- R8: With `hdr_ready` held high, `in_ready` stays high and one command is accepted and one header is delivered per cycle. At most two commands are in flight at any time.
- R9: While `hdr_valid` is high and `hdr_ready` is low, the header output holds its identifier and mask unchanged. No command is lost or reordered.
- R10: `hdr_cmd_id` equals the `in_cmd_id` of the command whose mask is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_band_cnt_m1 | input | CNT_W | Number of bands in use minus one |
| cfg_band_last | input | MAX_TILES*COORD_W | Last row of each band, band 0 in the low bits |
| cfg_screen_w | input | COORD_W | Screen width in pixels |
| in_valid | input | 1 | Command box is offered |
| in_ready | output | 1 | Block can take a command this cycle |
| in_cmd_id | input | ID_W | Command identifier |
| in_min_x | input | COORD_W | Leftmost pixel column of the box |
| in_max_x | input | COORD_W | Rightmost pixel column of the box |
| in_min_y | input | COORD_W | Top pixel row of the box |
| in_max_y | input | COORD_W | Bottom pixel row of the box |
| hdr_valid | output | 1 | Header write is offered |
| hdr_ready | input | 1 | Header store takes the write |
| hdr_cmd_id | output | ID_W | Identifier of the header being written |
| hdr_mask | output | MAX_TILES | One bit per band the command touches |

## Verification
The assertions take two things for granted. First, the configuration inputs stay fixed while any command is in flight. Second, the band last rows rise strictly from band to band, so the bands never overlap or run in reverse. The bench follows both rules. It changes the band table and screen width only after it has drained the pipeline and dropped `in_valid`, and every table it programs is strictly increasing. Within those limits the random boxes come from a mix of band-edge rows, inverted ranges and off-screen values, while `hdr_ready` is stalled at random.

// File: rtl/tmg_pkg.sv
// Package: tmg_pkg
// Shared helpers for the band tile mask generator.
// Assumes no coordinate in the design is wider than TMG_WIDE_W-1 bits.
package tmg_pkg;

    localparam int TMG_WIDE_W = 17;

    typedef logic [TMG_WIDE_W-1:0] tmg_wide_t;

    // True when inclusive ranges [a_lo,a_hi] and [b_lo,b_hi] share a value.
    function automatic logic tmg_overlap(
        input tmg_wide_t a_lo,
        input tmg_wide_t a_hi,
        input tmg_wide_t b_lo,
        input tmg_wide_t b_hi
    );
        return (a_lo <= b_hi) && (b_lo <= a_hi);
    endfunction

endpackage

// File: rtl/tmg_pipe_reg.sv
// Module: tmg_pipe_reg
// One valid/ready pipeline register. It takes new data when it is empty or
// when its content leaves in the same cycle. Assumes the upstream side holds
// its data stable while in_valid is high and in_ready is low.
module tmg_pipe_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    logic         vld_q;
    logic [W-1:0] dat_q;

    // Ready whenever the slot is free or is draining this cycle.
    always_comb begin
        in_ready = !vld_q || out_ready;
    end

    // Occupancy flag of the slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
        end else if (in_ready) begin
            vld_q <= in_valid;
        end
    end

    // Payload capture on every transfer into the slot.
    always_ff @(posedge clk) begin
        if (in_valid && in_ready) begin
            dat_q <= in_data;
        end
    end

    assign out_valid = vld_q;
    assign out_data  = dat_q;

endmodule

// File: rtl/tmg_band_table.sv
// Module: tmg_band_table
// Turns the programmed last row of each band into inclusive row ranges plus
// an in-use flag per band. Band 0 starts at row 0, and band i starts one row
// after band i-1 ends. Assumes the last rows rise strictly with band index.
module tmg_band_table #(
    parameter int MAX_TILES = 4,
    parameter int COORD_W   = 12,
    parameter int CNT_W     = 2
) (
    input  logic [MAX_TILES*COORD_W-1:0]   cfg_band_last,
    input  logic [CNT_W-1:0]               cfg_band_cnt_m1,
    output logic [MAX_TILES*(COORD_W+1)-1:0] band_top,
    output logic [MAX_TILES*(COORD_W+1)-1:0] band_bot,
    output logic [MAX_TILES-1:0]           band_en
);

    localparam int RW = COORD_W + 1;

    for (genvar gi = 0; gi < MAX_TILES; gi++) begin : g_band
        // Bottom row is the programmed value, widened by one bit.
        assign band_bot[gi*RW +: RW] = {1'b0, cfg_band_last[gi*COORD_W +: COORD_W]};

        if (gi == 0) begin : g_first
            // First band always starts at the top of the screen.
            assign band_top[gi*RW +: RW] = '0;
        end else begin : g_next
            // Later bands start on the row below the previous band.
            assign band_top[gi*RW +: RW] =
                {1'b0, cfg_band_last[(gi-1)*COORD_W +: COORD_W]} + RW'(1);
        end

        // A band is in use when its index is within the programmed count.
        assign band_en[gi] = (CNT_W'(gi) <= cfg_band_cnt_m1);
    end

endmodule

// File: rtl/tmg_mask_calc.sv
// Module: tmg_mask_calc
// Combinational mask builder. A bit is set for each in-use band whose row
// range overlaps the box's row range. A malformed box, or one whose left
// edge lies beyond the screen width, gives no bits.
module tmg_mask_calc
    import tmg_pkg::*;
#(
    parameter int MAX_TILES = 4,
    parameter int COORD_W   = 12
) (
    input  logic [COORD_W-1:0]               min_x,
    input  logic [COORD_W-1:0]               max_x,
    input  logic [COORD_W-1:0]               min_y,
    input  logic [COORD_W-1:0]               max_y,
    input  logic [COORD_W-1:0]               screen_w,
    input  logic [MAX_TILES*(COORD_W+1)-1:0] band_top,
    input  logic [MAX_TILES*(COORD_W+1)-1:0] band_bot,
    input  logic [MAX_TILES-1:0]             band_en,
    output logic [MAX_TILES-1:0]             mask
);

    localparam int RW = COORD_W + 1;

    logic box_ok;

    // Box is usable when both ranges are ordered and it starts on screen.
    always_comb begin
        box_ok = (min_x <= max_x) && (min_y <= max_y) && (min_x < screen_w);
    end

    for (genvar gi = 0; gi < MAX_TILES; gi++) begin : g_bit
        // Per-band overlap test on inclusive row ranges.
        assign mask[gi] = box_ok && band_en[gi] &&
            tmg_overlap(tmg_wide_t'(min_y), tmg_wide_t'(max_y),
                        tmg_wide_t'(band_top[gi*RW +: RW]),
                        tmg_wide_t'(band_bot[gi*RW +: RW]));
    end

endmodule

// File: rtl/tile_mask_gen.sv
// Module: tile_mask_gen
// Top of the band tile mask generator. Stage 1 registers the incoming
// command box. The mask is built from the stage 1 content, and stage 2
// registers the identifier and mask for the header store. Assumes the
// configuration inputs are stable while commands are in flight.
module tile_mask_gen #(
    parameter int ID_W      = 8,
    parameter int COORD_W   = 12,
    parameter int MAX_TILES = 4,
    localparam int CNT_W    = (MAX_TILES > 1) ? $clog2(MAX_TILES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CNT_W-1:0]             cfg_band_cnt_m1,
    input  logic [MAX_TILES*COORD_W-1:0] cfg_band_last,
    input  logic [COORD_W-1:0]           cfg_screen_w,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [ID_W-1:0]              in_cmd_id,
    input  logic [COORD_W-1:0]           in_min_x,
    input  logic [COORD_W-1:0]           in_max_x,
    input  logic [COORD_W-1:0]           in_min_y,
    input  logic [COORD_W-1:0]           in_max_y,
    output logic                         hdr_valid,
    input  logic                         hdr_ready,
    output logic [ID_W-1:0]              hdr_cmd_id,
    output logic [MAX_TILES-1:0]         hdr_mask
);

    localparam int RW   = COORD_W + 1;
    localparam int S1_W = ID_W + 4*COORD_W;
    localparam int S2_W = ID_W + MAX_TILES;

    logic [S1_W-1:0]           s1_in, s1_out;
    logic                      s1_valid, s2_in_ready;
    logic [S2_W-1:0]           s2_in, s2_out;
    logic [MAX_TILES*RW-1:0]   band_top, band_bot;
    logic [MAX_TILES-1:0]      band_en;
    logic [MAX_TILES-1:0]      mask_c;
    logic [ID_W-1:0]           s1_id;
    logic [COORD_W-1:0]        s1_min_x, s1_max_x, s1_min_y, s1_max_y;

    // Pack the incoming command for stage 1.
    always_comb begin
        s1_in = {in_cmd_id, in_min_x, in_max_x, in_min_y, in_max_y};
    end

    tmg_pipe_reg #(.W(S1_W)) u_stage1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (s1_in),
        .out_valid (s1_valid),
        .out_ready (s2_in_ready),
        .out_data  (s1_out)
    );

    // Unpack the stage 1 content.
    always_comb begin
        {s1_id, s1_min_x, s1_max_x, s1_min_y, s1_max_y} = s1_out;
    end

    tmg_band_table #(
        .MAX_TILES (MAX_TILES),
        .COORD_W   (COORD_W),
        .CNT_W     (CNT_W)
    ) u_bands (
        .cfg_band_last   (cfg_band_last),
        .cfg_band_cnt_m1 (cfg_band_cnt_m1),
        .band_top        (band_top),
        .band_bot        (band_bot),
        .band_en         (band_en)
    );

    tmg_mask_calc #(
        .MAX_TILES (MAX_TILES),
        .COORD_W   (COORD_W)
    ) u_mask (
        .min_x    (s1_min_x),
        .max_x    (s1_max_x),
        .min_y    (s1_min_y),
        .max_y    (s1_max_y),
        .screen_w (cfg_screen_w),
        .band_top (band_top),
        .band_bot (band_bot),
        .band_en  (band_en),
        .mask     (mask_c)
    );

    // Pack the identifier and computed mask for stage 2.
    always_comb begin
        s2_in = {s1_id, mask_c};
    end

    tmg_pipe_reg #(.W(S2_W)) u_stage2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s1_valid),
        .in_ready  (s2_in_ready),
        .in_data   (s2_in),
        .out_valid (hdr_valid),
        .out_ready (hdr_ready),
        .out_data  (s2_out)
    );

    // Drive the header write fields.
    always_comb begin
        {hdr_cmd_id, hdr_mask} = s2_out;
    end

endmodule

// File: rtl/tile_mask_gen_chk.sv
// Module: tile_mask_gen_chk
// Port-level checker for tile_mask_gen, attached with bind. Assumes the
// configuration is stable while commands are in flight.
module tile_mask_gen_chk #(
    parameter int MAX_TILES = 4,
    parameter int ID_W      = 8,
    parameter int CNT_W     = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 hdr_valid,
    input logic                 hdr_ready,
    input logic [ID_W-1:0]      hdr_cmd_id,
    input logic [MAX_TILES-1:0] hdr_mask,
    input logic [CNT_W-1:0]     cfg_band_cnt_m1
);

    logic [2:0] outst;

    // Commands accepted but not yet delivered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst <= '0;
        end else begin
            outst <= outst + {2'b0, (in_valid && in_ready)} - {2'b0, (hdr_valid && hdr_ready)};
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !hdr_valid);

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) ##1 hdr_ready |=> hdr_valid);

    assert_unused_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> ((hdr_mask >> ({1'b0, cfg_band_cnt_m1} + 1'b1)) == '0));

    assert_ready_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |-> in_ready);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        outst <= 3'd2);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && !hdr_ready |=> hdr_valid && $stable(hdr_cmd_id) && $stable(hdr_mask));

endmodule

bind tile_mask_gen tile_mask_gen_chk #(
    .MAX_TILES (MAX_TILES),
    .ID_W      (ID_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_valid        (in_valid),
    .in_ready        (in_ready),
    .hdr_valid       (hdr_valid),
    .hdr_ready       (hdr_ready),
    .hdr_cmd_id      (hdr_cmd_id),
    .hdr_mask        (hdr_mask),
    .cfg_band_cnt_m1 (cfg_band_cnt_m1)
);

// File: tb/tile_mask_gen_bench.sv
module tile_mask_gen_bench;

    localparam int CLK_P = 10;
    localparam int ID_W  = 8;
    localparam int CW    = 12;
    localparam int NT    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_band_cnt_m1 = 2'd2;
    logic [NT*CW-1:0] cfg_band_last = '0;
    logic [CW-1:0] cfg_screen_w = 12'd1280;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [ID_W-1:0] in_cmd_id = '0;
    logic [CW-1:0] in_min_x = '0, in_max_x = '0, in_min_y = '0, in_max_y = '0;
    logic          hdr_valid;
    logic          hdr_ready = 1'b1;
    logic [ID_W-1:0] hdr_cmd_id;
    logic [NT-1:0] hdr_mask;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;
    int  blast[NT];
    int  bcnt;
    int  bsw;
    logic [ID_W-1:0] next_id = '0;
    string cur_tag = "R3";
    bit  accepted;

    logic [ID_W-1:0] q_id[$];
    logic [NT-1:0]   q_mask[$];
    string           q_tag[$];

    tile_mask_gen u_tile_mask_gen (
        .clk (clk), .rst_n (rst_n),
        .cfg_band_cnt_m1 (cfg_band_cnt_m1), .cfg_band_last (cfg_band_last),
        .cfg_screen_w (cfg_screen_w),
        .in_valid (in_valid), .in_ready (in_ready), .in_cmd_id (in_cmd_id),
        .in_min_x (in_min_x), .in_max_x (in_max_x),
        .in_min_y (in_min_y), .in_max_y (in_max_y),
        .hdr_valid (hdr_valid), .hdr_ready (hdr_ready),
        .hdr_cmd_id (hdr_cmd_id), .hdr_mask (hdr_mask)
    );

    always #(CLK_P/2) clk = ~clk;

    // Reference mask from the requirements (R3..R7).
    function automatic logic [NT-1:0] ref_mask(int x0, int x1, int y0, int y1);
        logic [NT-1:0] m = '0;
        int top = 0;
        if (x0 > x1 || y0 > y1 || x0 >= bsw) return '0;
        for (int i = 0; i < bcnt; i++) begin
            if (y0 <= blast[i] && y1 >= top) m[i] = 1'b1;
            top = blast[i] + 1;
        end
        return m;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(int cnt, int b0, int b1, int b2, int b3, int sw);
        blast[0] = b0; blast[1] = b1; blast[2] = b2; blast[3] = b3;
        bcnt = cnt; bsw = sw;
        cfg_band_cnt_m1 = 2'(cnt - 1);
        cfg_band_last = {CW'(b3), CW'(b2), CW'(b1), CW'(b0)};
        cfg_screen_w = CW'(sw);
    endtask

    // Log transfers just before the edge, then move to the next falling edge.
    task automatic cycle();
        #(CLK_P/4);
        accepted = 0;
        if (hdr_valid && hdr_ready) begin
            if (q_id.size() == 0) begin
                check(0, "R9", int'(hdr_cmd_id), -1);
            end else begin
                check(hdr_cmd_id == q_id[0], "R10", int'(hdr_cmd_id), int'(q_id[0]));
                check(hdr_mask == q_mask[0], q_tag[0], int'(hdr_mask), int'(q_mask[0]));
                void'(q_id.pop_front()); void'(q_mask.pop_front()); void'(q_tag.pop_front());
            end
        end
        if (in_valid && in_ready) begin
            accepted = 1;
            q_id.push_back(in_cmd_id);
            q_mask.push_back(ref_mask(int'(in_min_x), int'(in_max_x), int'(in_min_y), int'(in_max_y)));
            q_tag.push_back(cur_tag);
        end
        @(negedge clk);
    endtask

    task automatic load(int x0, int x1, int y0, int y1);
        in_cmd_id = next_id; next_id++;
        in_min_x = CW'(x0); in_max_x = CW'(x1); in_min_y = CW'(y0); in_max_y = CW'(y1);
    endtask

    task automatic send(int x0, int x1, int y0, int y1, string tag);
        load(x0, x1, y0, y1);
        cur_tag = tag;
        in_valid = 1'b1;
        do cycle(); while (!accepted);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        in_valid = 1'b0;
        hdr_ready = 1'b1;
        for (int k = 0; k < 8; k++) cycle();
        check(q_id.size() == 0, "R9", q_id.size(), 0);
    endtask

    function automatic int pick_y();
        int r = int'($urandom % 8);
        int b = blast[$urandom % NT];
        case (r)
            0: return 0;
            1: return b;
            2: return b + 1;
            3: return b - 1;
            4: return 719;
            5: return 720;
            default: return int'($urandom % 1100);
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        set_cfg(3, 239, 479, 719, 1023, 1280);
        repeat (3) @(negedge clk);
        // R1: idle state during reset
        check(hdr_valid == 1'b0, "R1", hdr_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(hdr_valid == 1'b0, "R1", hdr_valid, 0);
        check(in_ready == 1'b1, "R1", in_ready, 1);

        // R2: two-edge latency
        load(10, 20, 100, 120);
        cur_tag = "R2";
        in_valid = 1'b1;
        cycle();
        in_valid = 1'b0;
        check(hdr_valid == 1'b0, "R2", hdr_valid, 0);
        cycle();
        check(hdr_valid == 1'b1, "R2", hdr_valid, 1);
        drain();

        // R4: boundary-spanning boxes
        send(0, 100, 200, 300, "R4");
        send(0, 1279, 0, 719, "R4");
        send(5, 5, 239, 240, "R4");
        // R3: single-band and edge-aligned boxes
        send(5, 5, 240, 240, "R3");
        send(5, 5, 479, 479, "R3");
        send(5, 5, 700, 900, "R3");
        // R5: malformed boxes
        send(5, 5, 300, 200, "R5");
        send(900, 100, 0, 10, "R5");
        // R6: off-screen boxes
        send(1280, 1300, 0, 10, "R6");
        send(0, 10, 720, 800, "R6");
        drain();

        // R7: fewer bands in use
        set_cfg(2, 239, 479, 719, 1023, 1280);
        send(0, 10, 0, 719, "R7");
        send(0, 10, 500, 600, "R7");
        drain();
        set_cfg(4, 99, 399, 719, 1023, 1920);
        send(0, 10, 720, 800, "R7");
        send(1500, 1900, 1024, 1100, "R6");
        drain();

        // R8: back-to-back stream with no stall
        hdr_ready = 1'b1;
        cur_tag = "R8";
        for (int k = 0; k < 10; k++) begin
            load(k, k + 50, k * 90, k * 90 + 40);
            in_valid = 1'b1;
            check(in_ready == 1'b1, "R8", in_ready, 1);
            if (k >= 2) check(hdr_valid == 1'b1, "R8", hdr_valid, 1);
            cycle();
        end
        drain();

        // R9: stall fills the pipeline, then everything drains in order
        hdr_ready = 1'b0;
        cur_tag = "R9";
        for (int k = 0; k < 4; k++) begin
            if (!in_valid || accepted) load(k * 10, k * 10 + 5, k * 200, k * 200 + 10);
            in_valid = 1'b1;
            cycle();
        end
        check(in_ready == 1'b0, "R9", in_ready, 0);
        drain();

        // R3: random mix with random output stalls and periodic reconfiguration
        for (int blk = 0; blk < 4; blk++) begin
            case (blk)
                0: set_cfg(3, 239, 479, 719, 1023, 1280);
                1: set_cfg(4, 150, 151, 600, 1000, 1024);
                2: set_cfg(1, 719, 800, 900, 1000, 1280);
                default: set_cfg(2, 359, 719, 800, 900, 640);
            endcase
            cur_tag = "R3";
            for (int n = 0; n < 600; n++) begin
                if (!in_valid || accepted) begin
                    int y0 = pick_y();
                    int y1 = ($urandom % 6 == 0) ? pick_y() : y0 + int'($urandom % 400);
                    int x0 = int'($urandom % 1400);
                    int x1 = ($urandom % 8 == 0) ? int'($urandom % 1400) : x0 + int'($urandom % 200);
                    if (y1 > 4095) y1 = 4095;
                    if (x1 > 4095) x1 = 4095;
                    load(x0, x1, y0, y1);
                    in_valid = ($urandom % 5 != 0);
                end
                hdr_ready = ($urandom % 4 != 0);
                cycle();
            end
            drain();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule